// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block walks one vector operation element by element when the source side and the destination side each have their own predicate mask. After a start strobe it captures the vector length, both masks, an invert option per mask and two base register numbers. It then hands a scalar execute stage one (source index, destination index) pair per accepted cycle. The first enabled source element goes with the first enabled destination element, the second with the second, and so on. The operation therefore gathers the selected sources together and scatters the results into the selected destinations.

A source element whose mask bit is clear is never read. A destination element whose mask bit is clear is never written. The run stops as soon as either side runs out of enabled elements. The block also forms register numbers as base plus index. As the example operation it sign-extends the low byte of the operand that the register file returns for the current source register.

Top module: `twin_pred_seq`

## Requirements
- R1: A start pulse seen while `busy` is low captures `vl`, both masks, both invert bits and both bases, and `busy` is high in the next cycle. A start pulse seen while `busy` is high is ignored: the running sequence and its pairs do not change, and no second run follows.
- R2: The effective source mask is `src_mask` with every bit inverted when `src_inv` is 1. The destination mask is formed the same way from `dst_mask` and `dst_inv`. In both effective masks, bit positions at or above `vl` are treated as 0.
- R3: Pairs are issued in ascending order. The k-th issued pair carries the index of the k-th set bit of the effective source mask, counted from bit 0, and the index of the k-th set bit of the effective destination mask.
- R4: `src_reg` equals `src_base + src_idx` and `dst_reg` equals `dst_base + dst_idx`, both taken modulo 128 (7-bit register numbers).
- R5: While `issue_valid` is high and `issue_ready` is low, the pair is held with the same indices. With `issue_ready` held high, one pair is accepted every cycle.
- R6: When either side has no enabled element left, `done` is high for exactly one cycle, with `issue_valid` low in that cycle. Enabled elements left over on the other side are never issued, and `busy` is low from the next cycle.
- R7: With `vl` = 0, or with an effective mask that is empty below `vl`, nothing is issued and `done` is high in the first cycle after the start pulse is captured.
- R8: `result` is the low byte of `src_data` sign-extended to 64 bits. For example, 0x91 gives 0xFFFF_FFFF_FFFF_FF91.
- R9: `vl` is 7 bits wide, so any value from 0 to 127 is accepted, and every issued index is below `vl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| start | input | 1 | Begin a sequence (acted on only when idle) |
| vl | input | 7 | Vector length |
| src_mask | input | 128 | Source predicate bits |
| dst_mask | input | 128 | Destination predicate bits |
| src_inv | input | 1 | Invert the source predicate |
| dst_inv | input | 1 | Invert the destination predicate |
| src_base | input | 7 | First register of the source vector |
| dst_base | input | 7 | First register of the destination vector |
| issue_ready | input | 1 | Execute stage accepts the current pair |
| src_data | input | 64 | Operand read from `src_reg` |
| busy | output | 1 | Sequence in progress |
| issue_valid | output | 1 | A pair is offered |
| src_idx | output | 7 | Source element index |
| dst_idx | output | 7 | Destination element index |
| src_reg | output | 7 | Source register number |
| dst_reg | output | 7 | Destination register number |
| result | output | 64 | Sign-extended low byte of `src_data` |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The block holds little state: two shrinking masks, the bases and a busy flag. A corrupted mask therefore shows up at the very next offered pair. It appears as a wrong index or register number, a pair that is not in order, or a `done` that comes early or late, and a scoreboard of expected pairs catches it on that same accept. A wrong capture at start, such as a lost invert, an unapplied length limit or a start taken while busy, shows up within the first one or two pairs. It can also show up as a missing `done` or an extra `done` within a few cycles of the run's end. Stalls are checked on every cycle that the pair is held.

// File: rtl/twin_pred_seq.sv
module twin_pred_seq #(
  parameter int VL_W   = 7,
  parameter int REG_W  = 7,
  parameter int DATA_W = 64,
  localparam int MAXVL = 1 << VL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl,
  input  logic [MAXVL-1:0]  src_mask,
  input  logic [MAXVL-1:0]  dst_mask,
  input  logic              src_inv,
  input  logic              dst_inv,
  input  logic [REG_W-1:0]  src_base,
  input  logic [REG_W-1:0]  dst_base,
  input  logic              issue_ready,
  input  logic [DATA_W-1:0] src_data,
  output logic              busy,
  output logic              issue_valid,
  output logic [VL_W-1:0]   src_idx,
  output logic [VL_W-1:0]   dst_idx,
  output logic [REG_W-1:0]  src_reg,
  output logic [REG_W-1:0]  dst_reg,
  output logic [DATA_W-1:0] result,
  output logic              done
);

  localparam logic [MAXVL-1:0] ONE = {{(MAXVL-1){1'b0}}, 1'b1};

  logic [MAXVL-1:0] smask_q, dmask_q, lim;
  logic [MAXVL-1:0] s_one, d_one;
  logic [VL_W-1:0]  vl_q;
  logic [REG_W-1:0] sbase_q, dbase_q;
  logic             busy_q, have_pair;

  function automatic logic [VL_W-1:0] oh_idx(input logic [MAXVL-1:0] oh);
    oh_idx = '0;
    for (int i = 0; i < MAXVL; i++)
      if (oh[i]) oh_idx = oh_idx | VL_W'(i);
  endfunction

  always_comb
    for (int i = 0; i < MAXVL; i++) lim[i] = (i < int'(vl));

  assign s_one     = smask_q & (~smask_q + ONE);
  assign d_one     = dmask_q & (~dmask_q + ONE);
  assign have_pair = (|smask_q) && (|dmask_q);

  assign busy        = busy_q;
  assign issue_valid = busy_q && have_pair;
  assign done        = busy_q && !have_pair;
  assign src_idx     = oh_idx(s_one);
  assign dst_idx     = oh_idx(d_one);
  assign src_reg     = sbase_q + REG_W'(src_idx);
  assign dst_reg     = dbase_q + REG_W'(dst_idx);
  assign result      = {{(DATA_W-8){src_data[7]}}, src_data[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      smask_q <= '0;
      dmask_q <= '0;
      vl_q    <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        smask_q <= (src_mask ^ {MAXVL{src_inv}}) & lim;
        dmask_q <= (dst_mask ^ {MAXVL{dst_inv}}) & lim;
        vl_q    <= vl;
        sbase_q <= src_base;
        dbase_q <= dst_base;
      end
    end else if (!have_pair) begin
      busy_q  <= 1'b0;
      smask_q <= '0;
      dmask_q <= '0;
    end else if (issue_ready) begin
      smask_q <= smask_q & ~s_one;
      dmask_q <= dmask_q & ~d_one;
    end
  end

  a_r6_valid_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_valid && done));

  a_r6_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |=>
      (issue_valid && $stable(src_idx) && $stable(dst_idx)));

  a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=>
      (!issue_valid || (src_idx > $past(src_idx) && dst_idx > $past(dst_idx))));

  a_r9_index_below_vl: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (src_idx < vl_q && dst_idx < vl_q));

  a_r1_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(vl_q));

endmodule

// File: tb/twin_pred_seq_tb.sv
module twin_pred_seq_tb;
  localparam int VL_W = 7, REG_W = 7, DW = 64, MAXVL = 128;
  localparam int QW = 2*VL_W + 2*REG_W + DW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [VL_W-1:0] vl = '0;
  logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
  logic src_inv = 1'b0, dst_inv = 1'b0;
  logic [REG_W-1:0] src_base = '0, dst_base = '0;
  logic issue_ready = 1'b1;
  logic [DW-1:0] src_data;
  logic busy, issue_valid, done;
  logic [VL_W-1:0] src_idx, dst_idx;
  logic [REG_W-1:0] src_reg, dst_reg;
  logic [DW-1:0] result;

  logic [DW-1:0] rf [MAXVL];
  logic [QW-1:0] q[$];
  int checks = 0, errors = 0, done_cnt = 0;
  bit rdy_mode = 1'b0, prev_stall = 1'b0;
  logic [VL_W-1:0] ps, pd;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  assign src_data = rf[src_reg];

  twin_pred_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
    .src_mask(src_mask), .dst_mask(dst_mask), .src_inv(src_inv), .dst_inv(dst_inv),
    .src_base(src_base), .dst_base(dst_base), .issue_ready(issue_ready),
    .src_data(src_data), .busy(busy), .issue_valid(issue_valid),
    .src_idx(src_idx), .dst_idx(dst_idx), .src_reg(src_reg), .dst_reg(dst_reg),
    .result(result), .done(done));

  function automatic logic [DW-1:0] sext8(input logic [DW-1:0] v);
    return {{(DW-8){v[7]}}, v[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [QW-1:0] act, input logic [QW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    issue_ready = rdy_mode ? lfsr[0] : 1'b1;
  end

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall)
        chk(issue_valid && src_idx == ps && dst_idx == pd, "R5 hold",
            QW'({issue_valid, src_idx, dst_idx}), QW'({1'b1, ps, pd}));
      if (issue_valid && issue_ready) begin
        if (q.size() == 0)
          chk(1'b0, "R6 unexpected issue", QW'({src_idx, dst_idx}), '0);
        else begin
          logic [QW-1:0] e;
          e = q.pop_front();
          chk({src_idx, dst_idx, src_reg, dst_reg, result} == e, "R3/R4/R8 pair",
              {src_idx, dst_idx, src_reg, dst_reg, result}, e);
        end
      end
      if (done) done_cnt++;
      prev_stall = issue_valid && !issue_ready;
      ps = src_idx;
      pd = dst_idx;
    end
  end

  task automatic run_vec(input int n, input logic [MAXVL-1:0] sm, input logic [MAXVL-1:0] dm,
                         input bit si, input bit di, input int sb, input int db,
                         input bit rmode, input bit poke);
    int sl[$], dl[$], k, d0;
    for (int i = 0; i < n; i++) begin
      if (sm[i] ^ si) sl.push_back(i);
      if (dm[i] ^ di) dl.push_back(i);
    end
    k = (sl.size() < dl.size()) ? sl.size() : dl.size();
    for (int j = 0; j < k; j++) begin
      logic [REG_W-1:0] sr, dr;
      sr = REG_W'(sb + sl[j]);
      dr = REG_W'(db + dl[j]);
      q.push_back({VL_W'(sl[j]), VL_W'(dl[j]), sr, dr, sext8(rf[sr])});
    end
    rdy_mode = rmode;
    d0 = done_cnt;
    @(negedge clk);
    vl = VL_W'(n); src_mask = sm; dst_mask = dm; src_inv = si; dst_inv = di;
    src_base = REG_W'(sb); dst_base = REG_W'(db); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #3;
    chk(busy, "R1 busy after start", QW'(busy), QW'(1));
    if (k == 0)
      chk(done && !issue_valid, "R7 done right after start", QW'({done, issue_valid}), QW'(2'b10));
    if (poke) begin
      repeat (3) @(negedge clk);
      vl = 7'd5; src_mask = '1; dst_mask = '1; src_inv = 1'b0; dst_inv = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int t = 0; t < 2000 && done_cnt == d0; t++) @(negedge clk);
    repeat (4) @(negedge clk);
    #3;
    chk(done_cnt == d0 + 1, "R6 single done", QW'(done_cnt - d0), QW'(1));
    chk(!busy && !issue_valid, "R6/R1 idle after done", QW'({busy, issue_valid}), '0);
    chk(q.size() == 0, "R3/R6 all pairs issued", QW'(q.size()), '0);
    q.delete();
    rdy_mode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAXVL; i++)
      rf[i] = 64'h0123_4567_89AB_0000 | DW'((i * 53 + 17) % 256);
    rf[9] = 64'h91;
    rf[10] = 64'h90;
    repeat (3) @(negedge clk);
    #3;
    chk(!busy && !issue_valid && !done, "R1 reset state", QW'({busy, issue_valid, done}), '0);
    rst_n = 1'b1;

    // R2 R3 R4 R8: inverted source from the same mask word, one pair 9 -> 6
    run_vec(2, 128'b10, 128'b10, 1'b1, 1'b0, 9, 5, 1'b0, 1'b0);
    // R5 full masks, random ready
    run_vec(8, '1, '1, 1'b0, 1'b0, 3, 40, 1'b1, 1'b0);
    // R2 bits above vl set must be ignored; R6 leftover dropped
    run_vec(20, 128'hFFFF_0000_0000_0000_0000_0000_0000_A5C3,
                128'hF0F0_0000_0000_0000_0000_0000_000F_0241, 1'b0, 1'b0, 0, 64, 1'b1, 1'b0);
    // R7 vl zero
    run_vec(0, '1, '1, 1'b0, 1'b0, 1, 2, 1'b0, 1'b0);
    // R7 empty mask below vl
    run_vec(16, 128'hFFFF_0000, '1, 1'b0, 1'b0, 1, 2, 1'b0, 1'b0);
    // R9 maximum vl, inverted destination, R4 wrap, R1 start while busy ignored
    run_vec(127, 128'h5555_5555_FFFF_0000_1234_5678_9ABC_DEF0,
                 128'h0F0F_0F0F_0000_FFFF_0000_0000_0000_0001, 1'b0, 1'b1, 100, 90, 1'b1, 1'b1);
    // R3 dense source vs sparse destination
    run_vec(64, '1, 128'h8000_0000_0000_0001_0000_0001_0001_0101, 1'b0, 1'b0, 60, 70, 1'b0, 1'b0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule